// File: doc/BRIEF.md
# Serial Storage Link Frame Engine

This block is the frame engine of the link layer on a 32-bit serial storage link. Every clock cycle it looks at one dword arriving from the PHY and, one cycle later, puts one dword on the line towards the PHY. Each outgoing dword carries a 4-bit control-character flag. When a frame waits in the transmit FIFO, the engine requests the line and waits for the peer's grant. It then sends a start delimiter, the payload, a check dword, an end delimiter, and a termination wait that lasts until the peer returns a good or bad status. The peer's flow-control holds are answered along the way.

When no frame is being sent, the engine acts as the receiver. It grants the peer's requests and acknowledges holds. It collects the data dwords of a frame that the peer opens. When the peer terminates the frame, the engine hands the frame upward, returns a good status on the line, and reports whether the frame's check dword matched. The real CRC and the scrambler are outside this block. The check dword is a placeholder: the XOR of a seed parameter and all payload dwords. It is produced by a small hook module that a CRC engine can replace.

Top module: `frame_link_engine`

## Requirements
- R1: After reset, and in every cycle where no frame is active in either direction, the engine sends SYNC. The line output changes one clock edge after the incoming dword that caused it.
- R2: Every primitive is sent with the K flag 4'b0001, and data and check dwords with 4'b0000. The primitive values are: SYNC=B5B5957C, XRDY=5757B57C, RRDY=4A4A957C, SOF=3737B57C, EOF=D5D5B57C, WTRM=5858B57C, HOLD=D5D5AA7C, HOLDA=9595AA7C, RIP=5555B57C, ROK=3535B57C, RERR=5656B57C. An incoming dword counts as a primitive only when its K flag is 4'b0001 and all 32 bits match one of these values. It counts as data only when its K flag is 4'b0000.
- R3: A transmit frame starts only when the FIFO is not empty, no received frame is open and the incoming dword is SYNC. The engine then sends XRDY in every cycle, up to and including the cycle in which RRDY is seen. After that it sends exactly one SOF.
- R4: After SOF, payload dwords go out in FIFO order, with one pop for each dword sent. In a cycle where the incoming dword is HOLD, the engine sends HOLDA instead and does not pop.
- R5: If the FIFO is empty in the middle of a frame, the engine sends HOLD and does not pop.
- R6: After the dword flagged last, the engine sends the check dword, which is the seed XOR all payload dwords. A HOLD in that cycle is answered with HOLDA first. Then it sends one EOF, and then sends WTRM until ROK or RERR arrives.
- R7: On ROK or RERR the engine sends SYNC and returns to idle. It pulses tx_done for one cycle, with tx_ok at 1 for ROK and 0 for RERR.
- R8: When no frame is being sent, an incoming XRDY is answered with RRDY, HOLD with HOLDA and WTRM with ROK. XRDY takes priority over starting a transmit frame.
- R9: An incoming SOF opens a received frame. While the frame is open, incoming data dwords and primitives other than XRDY, HOLD, WTRM and EOF are answered with RIP, and EOF is answered with SYNC. Each data dword except the last is delivered on rxo_data with rxo_valid, in order, one edge after the next data dword arrives.
- R10: A WTRM closes the open frame and pulses rxo_done for one cycle. rxo_good is 1 only when the last data dword equals the seed XOR all delivered dwords. A frame with no data dwords is bad.
- R11: A data dword that arrives with no frame open is not delivered. A WTRM that arrives with no frame open produces no rxo_done.
- R12: While a received frame is open, a pending transmit frame waits. It starts on the first SYNC after the frame closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phy_rx_data | input | 32 | Dword received from the PHY |
| phy_rx_k | input | 4 | Control-character flag of the received dword |
| phy_tx_data | output | 32 | Dword sent to the PHY (registered) |
| phy_tx_k | output | 4 | Control-character flag of the sent dword |
| txf_empty | input | 1 | Transmit FIFO holds no dword |
| txf_data | input | 32 | Head dword of the transmit FIFO (first-word fall-through) |
| txf_last | input | 1 | Head dword is the last one of its frame |
| txf_pop | output | 1 | Head dword is consumed at this clock edge |
| tx_done | output | 1 | One-cycle pulse when the peer returns a status |
| tx_ok | output | 1 | Status with tx_done: 1 good, 0 bad |
| rxo_valid | output | 1 | rxo_data holds a delivered payload dword |
| rxo_data | output | 32 | Delivered payload dword |
| rxo_done | output | 1 | One-cycle pulse when a received frame closes |
| rxo_good | output | 1 | Check result with rxo_done |

## Verification
The assertions check these rules on every cycle:
- Line dwords are well formed: each flag value goes only with a legal word.
- Each SOF is single.
- XRDY is repeated while the engine waits for a grant.
- A HOLD is answered with HOLDA, and no pop happens during payload or check.
- There is no pop from an empty FIFO.
- Both done signals are single-cycle pulses.
- An idle engine answers XRDY with RRDY.

Only the bench scenarios can show the rest:
- the exact order and values of payload and check dwords;
- the good and bad outcome for ROK, RERR, matching and mismatched check dwords and empty frames;
- the in-order delivery of received data with the check dword stripped;
- that stray dwords with no open frame are ignored;
- that a transmit frame is deferred behind an open received frame.

// File: rtl/fle_pkg.sv
package fle_pkg;

    localparam int DW     = 32;
    localparam int KW     = DW / 8;
    localparam int N_PRIM = 11;

    localparam logic [KW-1:0] K_CTRL = KW'(1);
    localparam logic [KW-1:0] K_NONE = '0;

    typedef enum logic [3:0] {
        PR_NONE  = 4'd0,
        PR_SYNC  = 4'd1,
        PR_XRDY  = 4'd2,
        PR_RRDY  = 4'd3,
        PR_SOF   = 4'd4,
        PR_EOF   = 4'd5,
        PR_WTRM  = 4'd6,
        PR_HOLD  = 4'd7,
        PR_HOLDA = 4'd8,
        PR_RIP   = 4'd9,
        PR_ROK   = 4'd10,
        PR_RERR  = 4'd11
    } prim_e;

    typedef enum logic [2:0] {
        LS_IDLE,
        LS_ASK,
        LS_SOF,
        LS_DATA,
        LS_CHK,
        LS_EOF,
        LS_WAIT
    } lstate_e;

    typedef struct packed {
        logic [DW-1:0] data;
        logic [KW-1:0] k;
    } dword_t;

    // Fixed 32-bit line codes; low byte is the K28.3 control character.
    function automatic logic [DW-1:0] prim_word(prim_e p);
        logic [DW-1:0] w;
        case (p)
            PR_SYNC:  w = 32'hB5B5_957C;
            PR_XRDY:  w = 32'h5757_B57C;
            PR_RRDY:  w = 32'h4A4A_957C;
            PR_SOF:   w = 32'h3737_B57C;
            PR_EOF:   w = 32'hD5D5_B57C;
            PR_WTRM:  w = 32'h5858_B57C;
            PR_HOLD:  w = 32'hD5D5_AA7C;
            PR_HOLDA: w = 32'h9595_AA7C;
            PR_RIP:   w = 32'h5555_B57C;
            PR_ROK:   w = 32'h3535_B57C;
            PR_RERR:  w = 32'h5656_B57C;
            default:  w = '0;
        endcase
        return w;
    endfunction

    function automatic dword_t ctrl(prim_e p);
        dword_t d;
        d.data = prim_word(p);
        d.k    = K_CTRL;
        return d;
    endfunction

    function automatic dword_t payload(logic [DW-1:0] v);
        dword_t d;
        d.data = v;
        d.k    = K_NONE;
        return d;
    endfunction

endpackage

// File: rtl/fle_classify.sv
module fle_classify
    import fle_pkg::*;
(
    input  logic [DW-1:0] data,
    input  logic [KW-1:0] k,
    output prim_e         kind,
    output logic          is_data
);

    logic [N_PRIM:1] hit;

    for (genvar i = 1; i <= N_PRIM; i++) begin : g_cmp
        assign hit[i] = (k == K_CTRL) && (data == prim_word(prim_e'(i)));
    end

    always_comb begin
        kind = PR_NONE;
        for (int i = 1; i <= N_PRIM; i++) begin
            if (hit[i]) kind = prim_e'(i);
        end
    end

    assign is_data = (k == K_NONE);

endmodule

// File: rtl/fle_chk_acc.sv
module fle_chk_acc
    import fle_pkg::*;
#(
    parameter logic [DW-1:0] SEED = 32'h5232_5032
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] acc
);

    // Placeholder check hook: seed XOR every accepted dword.
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc <= SEED;
        end else if (en) begin
            acc <= acc ^ din;
        end
    end

endmodule

// File: rtl/fle_rx_frame.sv
module fle_rx_frame
    import fle_pkg::*;
#(
    parameter logic [DW-1:0] SEED = 32'h5232_5032
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          open_i,
    input  logic          word_en_i,
    input  logic [DW-1:0] word_i,
    input  logic          close_i,
    output logic          out_valid_o,
    output logic [DW-1:0] out_data_o,
    output logic          done_o,
    output logic          good_o
);

    logic          held_v;
    logic [DW-1:0] held_d;
    logic [DW-1:0] acc;
    logic          emit;

    // A word leaves only once a successor proves it is not the check dword.
    assign emit = word_en_i && held_v;

    fle_chk_acc #(.SEED(SEED)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .clear (open_i),
        .en    (emit),
        .din   (held_d),
        .acc   (acc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            held_v      <= 1'b0;
            held_d      <= '0;
            out_valid_o <= 1'b0;
            out_data_o  <= '0;
            done_o      <= 1'b0;
            good_o      <= 1'b0;
        end else begin
            out_valid_o <= emit;
            done_o      <= close_i;
            good_o      <= close_i && held_v && (held_d == acc);
            if (emit) begin
                out_data_o <= held_d;
            end
            if (open_i || close_i) begin
                held_v <= 1'b0;
            end else if (word_en_i) begin
                held_v <= 1'b1;
                held_d <= word_i;
            end
        end
    end

endmodule

// File: rtl/frame_link_engine.sv
module frame_link_engine
    import fle_pkg::*;
#(
    parameter logic [DW-1:0] CHK_SEED = 32'h5232_5032
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] phy_rx_data,
    input  logic [KW-1:0] phy_rx_k,
    output logic [DW-1:0] phy_tx_data,
    output logic [KW-1:0] phy_tx_k,
    input  logic          txf_empty,
    input  logic [DW-1:0] txf_data,
    input  logic          txf_last,
    output logic          txf_pop,
    output logic          tx_done,
    output logic          tx_ok,
    output logic          rxo_valid,
    output logic [DW-1:0] rxo_data,
    output logic          rxo_done,
    output logic          rxo_good
);

    prim_e         rk;
    logic          r_data;
    lstate_e       st, st_nx;
    dword_t        out_q, out_nx;
    logic          pop, start, fin, fin_ok;
    logic          rx_open, open_p, close_p, word_p;
    logic [DW-1:0] tx_acc;

    fle_classify u_cls (
        .data    (phy_rx_data),
        .k       (phy_rx_k),
        .kind    (rk),
        .is_data (r_data)
    );

    fle_chk_acc #(.SEED(CHK_SEED)) u_tx_acc (
        .clk   (clk),
        .rst   (rst),
        .clear (start),
        .en    (pop),
        .din   (txf_data),
        .acc   (tx_acc)
    );

    fle_rx_frame #(.SEED(CHK_SEED)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .open_i      (open_p),
        .word_en_i   (word_p),
        .word_i      (phy_rx_data),
        .close_i     (close_p),
        .out_valid_o (rxo_valid),
        .out_data_o  (rxo_data),
        .done_o      (rxo_done),
        .good_o      (rxo_good)
    );

    always_comb begin
        st_nx   = st;
        out_nx  = ctrl(PR_SYNC);
        pop     = 1'b0;
        start   = 1'b0;
        fin     = 1'b0;
        fin_ok  = 1'b0;
        open_p  = 1'b0;
        close_p = 1'b0;
        word_p  = 1'b0;
        case (st)
            LS_IDLE: begin
                if (rk == PR_XRDY) begin
                    out_nx = ctrl(PR_RRDY);
                end else if (!txf_empty && !rx_open && rk == PR_SYNC) begin
                    start  = 1'b1;
                    out_nx = ctrl(PR_XRDY);
                    st_nx  = LS_ASK;
                end else if (rk == PR_WTRM) begin
                    out_nx  = ctrl(PR_ROK);
                    close_p = rx_open;
                end else if (rk == PR_HOLD) begin
                    out_nx = ctrl(PR_HOLDA);
                end else if (rk == PR_EOF) begin
                    out_nx = ctrl(PR_SYNC);
                end else if (rx_open) begin
                    out_nx = ctrl(PR_RIP);
                    word_p = r_data;
                end else if (rk == PR_SOF) begin
                    open_p = 1'b1;
                end
            end
            LS_ASK: begin
                out_nx = ctrl(PR_XRDY);
                if (rk == PR_RRDY) st_nx = LS_SOF;
            end
            LS_SOF: begin
                out_nx = ctrl(PR_SOF);
                st_nx  = LS_DATA;
            end
            LS_DATA: begin
                if (rk == PR_HOLD) begin
                    out_nx = ctrl(PR_HOLDA);
                end else if (txf_empty) begin
                    out_nx = ctrl(PR_HOLD);
                end else begin
                    out_nx = payload(txf_data);
                    pop    = 1'b1;
                    if (txf_last) st_nx = LS_CHK;
                end
            end
            LS_CHK: begin
                if (rk == PR_HOLD) begin
                    out_nx = ctrl(PR_HOLDA);
                end else begin
                    out_nx = payload(tx_acc);
                    st_nx  = LS_EOF;
                end
            end
            LS_EOF: begin
                out_nx = ctrl(PR_EOF);
                st_nx  = LS_WAIT;
            end
            LS_WAIT: begin
                if (rk == PR_ROK || rk == PR_RERR) begin
                    fin    = 1'b1;
                    fin_ok = (rk == PR_ROK);
                    st_nx  = LS_IDLE;
                end else begin
                    out_nx = ctrl(PR_WTRM);
                end
            end
            default: st_nx = LS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= LS_IDLE;
            out_q   <= ctrl(PR_SYNC);
            rx_open <= 1'b0;
            tx_done <= 1'b0;
            tx_ok   <= 1'b0;
        end else begin
            st      <= st_nx;
            out_q   <= out_nx;
            tx_done <= fin;
            tx_ok   <= fin && fin_ok;
            if (open_p) begin
                rx_open <= 1'b1;
            end else if (close_p) begin
                rx_open <= 1'b0;
            end
        end
    end

    assign phy_tx_data = out_q.data;
    assign phy_tx_k    = out_q.k;
    assign txf_pop     = pop;

endmodule

// File: rtl/fle_checker.sv
module fle_checker
    import fle_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic [DW-1:0] rx_data,
    input logic [KW-1:0] rx_k,
    input logic [DW-1:0] tx_data,
    input logic [KW-1:0] tx_k,
    input logic          txf_empty,
    input logic          txf_pop,
    input logic          tx_done,
    input logic          rxo_done,
    input lstate_e       st
);

    function automatic logic known(logic [DW-1:0] w);
        logic f;
        f = 1'b0;
        for (int i = 1; i <= N_PRIM; i++) begin
            if (w == prim_word(prim_e'(i))) f = 1'b1;
        end
        return f;
    endfunction

    logic rx_hold, rx_xrdy, tx_sof;
    assign rx_hold = (rx_k == K_CTRL) && (rx_data == prim_word(PR_HOLD));
    assign rx_xrdy = (rx_k == K_CTRL) && (rx_data == prim_word(PR_XRDY));
    assign tx_sof  = (tx_k == K_CTRL) && (tx_data == prim_word(PR_SOF));

    p_kflag_r2: assert property (@(posedge clk) disable iff (rst)
        (tx_k == K_NONE) || (tx_k == K_CTRL && known(tx_data)));

    p_sof_single_r3: assert property (@(posedge clk) disable iff (rst)
        tx_sof |=> !tx_sof);

    p_ask_xrdy_r3: assert property (@(posedge clk) disable iff (rst)
        (st == LS_ASK) |=> (tx_k == K_CTRL && tx_data == prim_word(PR_XRDY)));

    p_hold_answer_r4: assert property (@(posedge clk) disable iff (rst)
        (rx_hold && (st == LS_DATA || st == LS_CHK)) |=>
            (tx_k == K_CTRL && tx_data == prim_word(PR_HOLDA)));

    p_hold_nopop_r4: assert property (@(posedge clk) disable iff (rst)
        rx_hold |-> !txf_pop);

    p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (rst)
        txf_pop |-> !txf_empty);

    p_txdone_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> !tx_done);

    p_txdone_sync_r7: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> (tx_k == K_CTRL && tx_data == prim_word(PR_SYNC)));

    p_rrdy_answer_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_xrdy && st == LS_IDLE) |=>
            (tx_k == K_CTRL && tx_data == prim_word(PR_RRDY)));

    p_rxdone_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        rxo_done |=> !rxo_done);

endmodule

bind frame_link_engine fle_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_data   (phy_rx_data),
    .rx_k      (phy_rx_k),
    .tx_data   (phy_tx_data),
    .tx_k      (phy_tx_k),
    .txf_empty (txf_empty),
    .txf_pop   (txf_pop),
    .tx_done   (tx_done),
    .rxo_done  (rxo_done),
    .st        (st)
);

// File: tb/frame_link_engine_bench.sv
module frame_link_engine_bench;

    localparam logic [31:0] SEED   = 32'h5232_5032;
    localparam logic [31:0] W_SYNC = 32'hB5B5_957C;
    localparam logic [31:0] W_XRDY = 32'h5757_B57C;
    localparam logic [31:0] W_RRDY = 32'h4A4A_957C;
    localparam logic [31:0] W_SOF  = 32'h3737_B57C;
    localparam logic [31:0] W_EOF  = 32'hD5D5_B57C;
    localparam logic [31:0] W_WTRM = 32'h5858_B57C;
    localparam logic [31:0] W_HOLD = 32'hD5D5_AA7C;
    localparam logic [31:0] W_HLDA = 32'h9595_AA7C;
    localparam logic [31:0] W_RIP  = 32'h5555_B57C;
    localparam logic [31:0] W_ROK  = 32'h3535_B57C;
    localparam logic [31:0] W_RERR = 32'h5656_B57C;
    localparam logic [3:0]  KP     = 4'b0001;
    localparam logic [3:0]  KD     = 4'b0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] rx_d = W_SYNC;
    logic [3:0]  rx_k = KP;
    logic [31:0] tx_d;
    logic [3:0]  tx_k;
    logic        f_empty = 1'b1;
    logic [31:0] f_data = '0;
    logic        f_last = 1'b0;
    logic        txf_pop, tx_done, tx_ok, rxo_valid, rxo_done, rxo_good;
    logic [31:0] rxo_data;

    logic [32:0] fifo_q[$];
    logic [31:0] exp_q[$];
    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    frame_link_engine #(.CHK_SEED(SEED)) u_frame_link_engine (
        .clk(clk), .rst(rst),
        .phy_rx_data(rx_d), .phy_rx_k(rx_k),
        .phy_tx_data(tx_d), .phy_tx_k(tx_k),
        .txf_empty(f_empty), .txf_data(f_data), .txf_last(f_last), .txf_pop(txf_pop),
        .tx_done(tx_done), .tx_ok(tx_ok),
        .rxo_valid(rxo_valid), .rxo_data(rxo_data),
        .rxo_done(rxo_done), .rxo_good(rxo_good)
    );

    task automatic refresh();
        f_empty = (fifo_q.size() == 0);
        f_data  = f_empty ? 32'h0 : fifo_q[0][31:0];
        f_last  = f_empty ? 1'b0 : fifo_q[0][32];
    endtask

    task automatic push_tx(input logic last, input logic [31:0] d);
        fifo_q.push_back({last, d});
        refresh();
    endtask

    task automatic chk(input string req, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic line(input string req, input logic [31:0] w, input logic [3:0] k);
        chk(req, "line", {tx_k, tx_d}, {k, w});
    endtask

    // Drive one incoming dword; return just after the edge that answers it.
    task automatic step(input logic [31:0] d, input logic [3:0] k);
        logic popped;
        rx_d = d;
        rx_k = k;
        @(negedge clk);
        #8;
        popped = txf_pop;
        @(posedge clk);
        #1;
        if (popped && fifo_q.size() != 0) begin
            fifo_q.delete(0);
            refresh();
        end
    endtask

    task automatic sp(input logic [31:0] w);
        step(w, KP);
    endtask

    task automatic sd(input logic [31:0] w);
        step(w, KD);
    endtask

    // Scoreboard monitor for delivered payload (R9, R11).
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (!rst && rxo_valid) begin
                if (exp_q.size() == 0) begin
                    n_chk++;
                    n_err++;
                    $display("FAIL R11 unexpected delivery: actual %h expected none", rxo_data);
                end else begin
                    chk("R9", "delivered", {4'h0, rxo_data}, {4'h0, exp_q[0]});
                    exp_q.delete(0);
                end
            end
        end
    end

    initial begin
        #4000000;
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, b, c, d0, d1, d2;
        a = 32'h1111_0001; b = 32'h2222_0002; c = 32'h3333_0003;
        refresh();
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        line("R1", W_SYNC, KP);
        chk("R1", "reset tx_done", {35'h0, tx_done}, 36'h0);
        chk("R1", "reset rxo_done", {35'h0, rxo_done}, 36'h0);
        sp(W_SYNC);
        line("R1", W_SYNC, KP);

        // Transmit frame with holds and good status.
        push_tx(1'b0, a); push_tx(1'b0, b); push_tx(1'b1, c);
        sp(W_SYNC);  line("R3", W_XRDY, KP);
        sp(W_SYNC);  line("R3", W_XRDY, KP);
        sp(W_RRDY);  line("R3", W_XRDY, KP);
        sp(W_SYNC);  line("R3", W_SOF, KP);
        sp(W_RIP);   line("R4", a, KD);
        sp(W_HOLD);  line("R4", W_HLDA, KP);
        chk("R4", "no pop on HOLD", {4'h0, 32'(fifo_q.size())}, 36'd2);
        sp(W_RIP);   line("R4", b, KD);
        sp(W_RIP);   line("R2", c, KD);
        sp(W_HOLD);  line("R6", W_HLDA, KP);
        sp(W_RIP);   line("R6", SEED ^ a ^ b ^ c, KD);
        sp(W_RIP);   line("R6", W_EOF, KP);
        sp(W_RIP);   line("R6", W_WTRM, KP);
        sp(W_RIP);   line("R6", W_WTRM, KP);
        chk("R7", "no early done", {35'h0, tx_done}, 36'h0);
        sp(W_ROK);   line("R7", W_SYNC, KP);
        chk("R7", "done on ROK", {34'h0, tx_done, tx_ok}, 36'h3);
        sp(W_SYNC);  line("R1", W_SYNC, KP);
        chk("R7", "done is a pulse", {35'h0, tx_done}, 36'h0);

        // FIFO underflow mid-frame, then bad status.
        d0 = 32'hAB00_0010; d1 = 32'hAB00_0020;
        push_tx(1'b0, d0);
        sp(W_SYNC);  line("R3", W_XRDY, KP);
        sp(W_RRDY);  line("R3", W_XRDY, KP);
        sp(W_SYNC);  line("R3", W_SOF, KP);
        sp(W_SYNC);  line("R4", d0, KD);
        sp(W_SYNC);  line("R5", W_HOLD, KP);
        push_tx(1'b1, d1);
        sp(W_SYNC);  line("R5", d1, KD);
        sp(W_SYNC);  line("R6", SEED ^ d0 ^ d1, KD);
        sp(W_SYNC);  line("R6", W_EOF, KP);
        sp(W_SYNC);  line("R6", W_WTRM, KP);
        sp(W_RERR);  line("R7", W_SYNC, KP);
        chk("R7", "done on RERR", {34'h0, tx_done, tx_ok}, 36'h2);

        // Receive a good frame.
        d0 = 32'hCAFE_0001; d1 = 32'h0BAD_F00D; d2 = 32'h1234_5678;
        exp_q.push_back(d0); exp_q.push_back(d1); exp_q.push_back(d2);
        sp(W_XRDY);  line("R8", W_RRDY, KP);
        sp(W_SOF);   line("R9", W_SYNC, KP);
        sd(d0);      line("R9", W_RIP, KP);
        sd(d1);      line("R9", W_RIP, KP);
        sp(W_SYNC);  line("R9", W_RIP, KP);
        sp(W_HOLD);  line("R8", W_HLDA, KP);
        sd(d2);      line("R9", W_RIP, KP);
        sd(SEED ^ d0 ^ d1 ^ d2); line("R9", W_RIP, KP);
        sp(W_EOF);   line("R9", W_SYNC, KP);
        sp(W_WTRM);  line("R8", W_ROK, KP);
        chk("R10", "good frame", {34'h0, rxo_done, rxo_good}, 36'h3);
        sp(W_SYNC);
        chk("R10", "done is a pulse", {35'h0, rxo_done}, 36'h0);
        chk("R9", "all delivered", {4'h0, 32'(exp_q.size())}, 36'h0);

        // Bad check dword and empty frame.
        exp_q.push_back(d0);
        sp(W_SOF);
        sd(d0);
        sd(32'hDEAD_BEEF);
        sp(W_WTRM);
        chk("R10", "bad check", {34'h0, rxo_done, rxo_good}, 36'h2);
        sp(W_SOF);
        sp(W_WTRM);
        chk("R10", "empty frame", {34'h0, rxo_done, rxo_good}, 36'h2);

        // Dwords with no open frame.
        sd(32'h7777_7777); line("R11", W_SYNC, KP);
        sd(32'h8888_8888);
        chk("R11", "no delivery", {35'h0, rxo_valid}, 36'h0);
        sp(W_WTRM);  line("R11", W_ROK, KP);
        chk("R11", "no done without frame", {35'h0, rxo_done}, 36'h0);

        // Pending transmit frame deferred behind receive side.
        push_tx(1'b1, a);
        sp(W_XRDY);  line("R12", W_RRDY, KP);
        sp(W_SOF);   line("R12", W_SYNC, KP);
        sd(b);       line("R12", W_RIP, KP);
        sp(W_SYNC);  line("R12", W_RIP, KP);
        sp(W_WTRM);  line("R12", W_ROK, KP);
        chk("R12", "frame closed", {35'h0, rxo_done}, 36'h1);
        sp(W_SYNC);  line("R12", W_XRDY, KP);
        sp(W_RRDY);  line("R3", W_XRDY, KP);
        sp(W_SYNC);  line("R3", W_SOF, KP);
        sp(W_SYNC);  line("R4", a, KD);
        sp(W_SYNC);  line("R6", SEED ^ a, KD);
        sp(W_SYNC);  line("R6", W_EOF, KP);
        sp(W_SYNC);  line("R6", W_WTRM, KP);
        sp(W_ROK);
        chk("R7", "deferred frame done", {34'h0, tx_done, tx_ok}, 36'h3);
        sp(W_SYNC);  line("R1", W_SYNC, KP);
        chk("R9", "scoreboard drained", {4'h0, 32'(exp_q.size())}, 36'h0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule